// File: doc/BRIEF.md
# Prioritized Route Lookup Unit

The unit keeps a lookup table of 4096 words of 12 bits and serves two inbound streams, each with a valid/ready handshake. The first stream carries table accesses, which are writes or reads chosen by a one-bit opcode. The second stream carries packet headers. A combinational scheduler accepts at most one transaction per clock. It takes them in fixed priority: table write first, then table read, then route. A transaction is accepted only when its guard holds, meaning the stream head is present, of the right kind, and its results have somewhere to go.

A table read puts the stored word on a reply queue. A route uses the low 12 bits of the header as the key. It reads the table at that key, and the low two bits of the stored word choose one of four output queues. The whole header is pushed onto that queue. Both kinds of lookup pass through a one-stage pipeline behind a synchronous table read. The scheduler holds a pending write back until no lookup is in flight, and holds routes back while a write is pending. Because of this, every transaction behaves as if the transactions ran one at a time, in acceptance order.

Top module: `route_lookup_unit`

## Requirements
- R1: A write access (`acc_op`=1) stores `acc_wdata` at `acc_addr`, and any later read or route at that address sees the new word.
- R2: A read access (`acc_op`=0) places the word stored at `acc_addr` on `rsp_data` with `rsp_valid` high. Replies leave in request order.
- R3: A packet whose header is accepted leaves unchanged on output queue `v[1:0]`. Here `v` is the table word at key `hdr[11:0]`, and queue q uses `out_valid[q]` and `out_data[16*q +: 16]`.
- R4: At most one of the write, read and route transactions is accepted per cycle. When both streams have a head that can fire, the access wins over the packet.
- R5: Only the opcode selects between write and read; a read leaves the table unchanged.
- R6: A write is not accepted while a route lookup is in flight. While a write sits at the head of the access stream, no packet is accepted. A packet accepted before a write is routed with the old table word, and one accepted after it with the new word.
- R7: Packets on each output queue leave in acceptance order. No accepted packet or read is lost.
- R8: A packet is accepted only when every output queue can take one more entry beyond the lookups in flight. Otherwise `pkt_ready` stays low and the packet waits at the head.
- R9: A read is accepted only when the reply queue can take one more entry beyond the reads in flight. Otherwise `acc_ready` stays low.
- R10: After reset, `rsp_valid` and every `out_valid` bit are low and all queues are empty.
- R11: While an output or the reply is valid and not taken, its valid stays high and its data stays stable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| acc_valid | input | 1 | Table access request present |
| acc_ready | output | 1 | Table access accepted this cycle |
| acc_op | input | 1 | 1 = write, 0 = read |
| acc_addr | input | 12 | Table address |
| acc_wdata | input | 12 | Word to write |
| rsp_valid | output | 1 | Reply word present |
| rsp_ready | input | 1 | Reply consumer takes the word |
| rsp_data | output | 12 | Reply word |
| pkt_valid | input | 1 | Packet header present |
| pkt_ready | output | 1 | Packet accepted this cycle |
| pkt_hdr | input | 16 | Packet header; bits 11:0 are the key |
| out_valid | output | 4 | One valid bit per output queue |
| out_ready | input | 4 | One ready bit per output queue |
| out_data | output | 64 | Headers, 16 bits per queue |

## Verification
The bench drives a write and a packet in the same cycle, and then a read and a packet, to check the priority order. A scheduler with the wrong order lets the packet through first. It also accepts a packet and presents a rewrite of that packet's key in the next cycle. A design that did not drain the lookup before the write, or did not hold routes behind a pending write, would stall wrongly or send the packets to the wrong queue. With the output queues and then the reply queue stalled, it checks that exactly two items are accepted, that the waiting head stays stable, and that everything arrives once the stall is released. A design with a weak guard would overflow a queue and drop or duplicate items.

// File: rtl/rlu_pkg.sv
package rlu_pkg;
  localparam logic OP_WRITE = 1'b1;
  localparam logic OP_READ  = 1'b0;

  typedef struct packed {
    logic wr;
    logic rd;
    logic rt;
  } fire_t;
endpackage

// File: rtl/rlu_table.sv
module rlu_table #(
  parameter int AW = 12,
  parameter int DW = 12
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int ENTRIES = 1 << AW;

  logic [DW-1:0] mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    if (re) rdata <= mem[raddr];
  end
endmodule

// File: rtl/rlu_fifo.sv
module rlu_fifo #(
  parameter int W     = 16,
  parameter int DEPTH = 2,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic [W-1:0]     din,
  input  logic             pop,
  output logic [W-1:0]     dout,
  output logic             valid,
  output logic [CNT_W-1:0] cnt
);
  logic [W-1:0]     slots [DEPTH];
  logic [PTR_W-1:0] wptr, rptr;
  logic             do_pop;

  assign do_pop = pop && valid;
  assign valid  = (cnt != '0);
  assign dout   = slots[rptr];

  function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) begin
        slots[wptr] <= din;
        wptr        <= bump(wptr);
      end
      if (do_pop) rptr <= bump(rptr);
      if (push && !do_pop)      cnt <= cnt + 1'b1;
      else if (!push && do_pop) cnt <= cnt - 1'b1;
    end
  end

  // R8 / R9: the upstream guard must never push into a full queue
  a_r8_no_overflow: assert property (@(posedge clk) disable iff (rst)
    push |-> (int'(cnt) < DEPTH));

  // R11: an unconsumed head keeps its value and its valid
  a_r11_head_hold: assert property (@(posedge clk) disable iff (rst)
    (valid && !pop) |=> (valid && $stable(dout)));
endmodule

// File: rtl/rlu_sched.sv
module rlu_sched
  import rlu_pkg::*;
(
  input  logic  acc_valid,
  input  logic  acc_op,
  input  logic  pkt_valid,
  input  logic  lookup_busy,
  input  logic  reply_room,
  input  logic  outq_room,
  output fire_t fire
);
  logic wr_head, rd_head;

  assign wr_head = acc_valid && (acc_op == OP_WRITE);
  assign rd_head = acc_valid && (acc_op == OP_READ);

  always_comb begin
    fire    = '0;
    fire.wr = wr_head && !lookup_busy;
    fire.rd = rd_head && reply_room;
    // a pending write blocks routes so the lookup stage drains
    fire.rt = pkt_valid && !wr_head && !fire.rd && outq_room;
  end
endmodule

// File: rtl/route_lookup_unit.sv
module route_lookup_unit
  import rlu_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DATA_W  = 12,
  parameter int HDR_W   = 16,
  parameter int NUM_Q   = 4,
  parameter int Q_DEPTH = 2,
  parameter int R_DEPTH = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   acc_valid,
  output logic                   acc_ready,
  input  logic                   acc_op,
  input  logic [ADDR_W-1:0]      acc_addr,
  input  logic [DATA_W-1:0]      acc_wdata,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [DATA_W-1:0]      rsp_data,
  input  logic                   pkt_valid,
  output logic                   pkt_ready,
  input  logic [HDR_W-1:0]       pkt_hdr,
  output logic [NUM_Q-1:0]       out_valid,
  input  logic [NUM_Q-1:0]       out_ready,
  output logic [NUM_Q*HDR_W-1:0] out_data
);
  localparam int QSEL_W  = (NUM_Q > 1) ? $clog2(NUM_Q) : 1;
  localparam int QCNT_W  = $clog2(Q_DEPTH + 1);
  localparam int RCNT_W  = $clog2(R_DEPTH + 1);

  fire_t             fire;
  logic              lk_valid, rd_valid;
  logic [HDR_W-1:0]  lk_hdr;
  logic [DATA_W-1:0] tbl_rdata;
  logic [ADDR_W-1:0] rd_addr;
  logic [QSEL_W-1:0] lk_q;
  logic [NUM_Q-1:0]  q_room, q_push;
  logic [QCNT_W-1:0] q_cnt [NUM_Q];
  logic [RCNT_W-1:0] rsp_cnt;
  logic              reply_room;

  assign lk_q       = tbl_rdata[QSEL_W-1:0];
  assign rd_addr    = fire.rt ? pkt_hdr[ADDR_W-1:0] : acc_addr;
  assign reply_room = (int'(rsp_cnt) + (rd_valid ? 1 : 0)) < R_DEPTH;
  assign acc_ready  = fire.wr || fire.rd;
  assign pkt_ready  = fire.rt;

  rlu_sched u_sched (
    .acc_valid   (acc_valid),
    .acc_op      (acc_op),
    .pkt_valid   (pkt_valid),
    .lookup_busy (lk_valid),
    .reply_room  (reply_room),
    .outq_room   (&q_room),
    .fire        (fire)
  );

  rlu_table #(.AW(ADDR_W), .DW(DATA_W)) u_table (
    .clk   (clk),
    .we    (fire.wr),
    .waddr (acc_addr),
    .wdata (acc_wdata),
    .re    (fire.rd || fire.rt),
    .raddr (rd_addr),
    .rdata (tbl_rdata)
  );

  // one-stage lookup pipeline behind the synchronous table read
  always_ff @(posedge clk) begin
    if (rst) begin
      lk_valid <= 1'b0;
      rd_valid <= 1'b0;
      lk_hdr   <= '0;
    end else begin
      lk_valid <= fire.rt;
      rd_valid <= fire.rd;
      if (fire.rt) lk_hdr <= pkt_hdr;
    end
  end

  rlu_fifo #(.W(DATA_W), .DEPTH(R_DEPTH)) u_reply (
    .clk   (clk),
    .rst   (rst),
    .push  (rd_valid),
    .din   (tbl_rdata),
    .pop   (rsp_ready),
    .dout  (rsp_data),
    .valid (rsp_valid),
    .cnt   (rsp_cnt)
  );

  for (genvar g = 0; g < NUM_Q; g++) begin : g_outq
    assign q_push[g] = lk_valid && (lk_q == QSEL_W'(g));
    assign q_room[g] = (int'(q_cnt[g]) + (q_push[g] ? 1 : 0)) < Q_DEPTH;

    rlu_fifo #(.W(HDR_W), .DEPTH(Q_DEPTH)) u_q (
      .clk   (clk),
      .rst   (rst),
      .push  (q_push[g]),
      .din   (lk_hdr),
      .pop   (out_ready[g]),
      .dout  (out_data[g*HDR_W +: HDR_W]),
      .valid (out_valid[g]),
      .cnt   (q_cnt[g])
    );
  end

  // R4: the scheduler fires at most one transaction per cycle
  a_r4_single_fire: assert property (@(posedge clk) disable iff (rst)
    $onehot0({fire.wr, fire.rd, fire.rt}));

  // R6: a write only lands once the lookup stage is empty
  a_r6_write_drained: assert property (@(posedge clk) disable iff (rst)
    fire.wr |-> !lk_valid);

  // R6: a write waiting at the access head keeps packets out
  a_r6_route_held: assert property (@(posedge clk) disable iff (rst)
    (acc_valid && acc_op == OP_WRITE) |-> !pkt_ready);

  // R3: every accepted packet reaches exactly one output queue next cycle
  a_r3_one_target: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |=> ($countones(q_push) == 1));
endmodule

// File: tb/route_lookup_unit_bench.sv
module route_lookup_unit_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        acc_valid = 1'b0, acc_op = 1'b0;
  logic [11:0] acc_addr = '0, acc_wdata = '0;
  logic        acc_ready, rsp_valid;
  logic        rsp_ready = 1'b1;
  logic [11:0] rsp_data;
  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [15:0] pkt_hdr = '0;
  logic [3:0]  out_valid;
  logic [3:0]  out_ready = 4'hF;
  logic [63:0] out_data;

  int n_chk = 0, n_fail = 0;
  int n_pkt_acc = 0, n_rd_acc = 0;
  logic [11:0] model [int];
  logic [11:0] exp_rsp [$];
  logic [15:0] exp_out [4][$];

  route_lookup_unit u_route_lookup_unit (
    .clk(clk), .rst(rst),
    .acc_valid(acc_valid), .acc_ready(acc_ready), .acc_op(acc_op),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .pkt_valid(pkt_valid), .pkt_ready(pkt_ready), .pkt_hdr(pkt_hdr),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  // scoreboard: acceptance pushes expectations, outputs pop and compare
  always @(negedge clk) begin
    if (!rst) begin
      if (acc_valid && acc_ready) begin
        if (acc_op) model[int'(acc_addr)] = acc_wdata;
        else begin
          exp_rsp.push_back(model[int'(acc_addr)]);
          n_rd_acc++;
        end
      end
      if (pkt_valid && pkt_ready) begin
        exp_out[int'(model[int'(pkt_hdr[11:0])][1:0])].push_back(pkt_hdr);
        n_pkt_acc++;
      end
      if (rsp_valid && rsp_ready) begin
        if (exp_rsp.size() == 0) chk(0, "R2", "unexpected reply", int'(rsp_data), 0);
        else begin
          logic [11:0] e;
          e = exp_rsp.pop_front();
          chk(rsp_data == e, "R2", "reply word", int'(rsp_data), int'(e));
        end
      end
      for (int q = 0; q < 4; q++) begin
        if (out_valid[q] && out_ready[q]) begin
          if (exp_out[q].size() == 0)
            chk(0, "R3", "packet on unexpected queue", q, 0);
          else begin
            logic [15:0] e;
            e = exp_out[q].pop_front();
            chk(out_data[q*16 +: 16] == e, "R7", "queue order/header",
                int'(out_data[q*16 +: 16]), int'(e));
          end
        end
      end
    end
  end

  task automatic send_acc(input logic op, input logic [11:0] a, input logic [11:0] d);
    acc_valid = 1'b1; acc_op = op; acc_addr = a; acc_wdata = d;
    do @(negedge clk); while (!acc_ready);
    @(posedge clk); #1;
    acc_valid = 1'b0;
  endtask

  task automatic send_pkt(input logic [15:0] h);
    pkt_valid = 1'b1; pkt_hdr = h;
    do @(negedge clk); while (!pkt_ready);
    @(posedge clk); #1;
    pkt_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic finish_run;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    int base;
    logic [15:0] held;
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R10: nothing valid after reset
    chk(rsp_valid == 1'b0, "R10", "rsp_valid after reset", int'(rsp_valid), 0);
    chk(out_valid == 4'h0, "R10", "out_valid after reset", int'(out_valid), 0);
    chk(acc_ready == 1'b0 && pkt_ready == 1'b0, "R10", "ready idle",
        int'({acc_ready, pkt_ready}), 0);
    @(posedge clk); #1;

    // R1 R5: fill keys 0..7 and the top address, then read back (R2)
    for (int k = 0; k < 8; k++)
      send_acc(1'b1, 12'(k), 12'((k << 4) | ((k * 3) & 3)));
    send_acc(1'b1, 12'hFFF, 12'hABE);
    for (int k = 0; k < 8; k++) send_acc(1'b0, 12'(k), 12'h000);
    send_acc(1'b0, 12'hFFF, 12'h000);
    idle(6);

    // R3 R7: route a burst over all queues, upper header bits vary
    for (int i = 0; i < 12; i++) send_pkt({4'(i), 12'(i % 8)});
    send_pkt(16'h5FFF);
    idle(6);

    // R4: write and packet together, the write wins
    acc_valid = 1'b1; acc_op = 1'b1; acc_addr = 12'h010; acc_wdata = 12'h001;
    pkt_valid = 1'b1; pkt_hdr = 16'h1003;
    @(negedge clk);
    chk(acc_ready == 1'b1, "R4", "write accepted over packet", int'(acc_ready), 1);
    chk(pkt_ready == 1'b0, "R4", "packet held behind write", int'(pkt_ready), 0);
    @(posedge clk); #1 acc_valid = 1'b0;
    @(negedge clk);
    chk(pkt_ready == 1'b1, "R3", "packet accepted once alone", int'(pkt_ready), 1);
    @(posedge clk); #1;
    // R4: read and packet together, the read wins
    acc_valid = 1'b1; acc_op = 1'b0; acc_addr = 12'h010;
    @(negedge clk);
    chk(acc_ready == 1'b1 && pkt_ready == 1'b0, "R4", "read over packet",
        int'({acc_ready, pkt_ready}), 2);
    @(posedge clk); #1 acc_valid = 1'b0;
    @(negedge clk);
    @(posedge clk); #1 pkt_valid = 1'b0;
    idle(6);

    // R6: packet, then a rewrite of its key while it is in flight
    pkt_valid = 1'b1; pkt_hdr = 16'h2002;
    @(negedge clk);
    chk(pkt_ready == 1'b1, "R6", "first packet accepted", int'(pkt_ready), 1);
    @(posedge clk); #1;
    pkt_hdr = 16'h3002;
    acc_valid = 1'b1; acc_op = 1'b1; acc_addr = 12'h002; acc_wdata = 12'h021;
    @(negedge clk);
    chk(acc_ready == 1'b0, "R6", "write waits for lookup", int'(acc_ready), 0);
    chk(pkt_ready == 1'b0, "R6", "packet held by pending write", int'(pkt_ready), 0);
    @(posedge clk); #1;
    @(negedge clk);
    chk(acc_ready == 1'b1, "R6", "write after drain", int'(acc_ready), 1);
    @(posedge clk); #1 acc_valid = 1'b0;
    @(negedge clk);
    chk(pkt_ready == 1'b1, "R6", "second packet after write", int'(pkt_ready), 1);
    @(posedge clk); #1 pkt_valid = 1'b0;
    idle(6);

    // R8 R11: stall every output queue, key 1 targets queue 3
    out_ready = 4'h0;
    base = n_pkt_acc;
    fork
      begin
        for (int i = 0; i < 4; i++) send_pkt({4'(i + 8), 12'h001});
      end
      begin
        repeat (10) @(negedge clk);
        chk(n_pkt_acc - base == 2, "R8", "packets accepted while stalled",
            n_pkt_acc - base, 2);
        chk(pkt_ready == 1'b0, "R8", "packet waits at head", int'(pkt_ready), 0);
        held = out_data[3*16 +: 16];
        @(negedge clk);
        chk(out_valid[3] == 1'b1 && out_data[3*16 +: 16] == held, "R11",
            "stalled head stable", int'(out_data[3*16 +: 16]), int'(held));
        @(posedge clk); #1 out_ready = 4'hF;
      end
    join
    idle(8);

    // R9: stall the reply queue
    rsp_ready = 1'b0;
    base = n_rd_acc;
    fork
      begin
        for (int i = 0; i < 4; i++) send_acc(1'b0, 12'(i), 12'h000);
      end
      begin
        repeat (10) @(negedge clk);
        chk(n_rd_acc - base == 2, "R9", "reads accepted while stalled",
            n_rd_acc - base, 2);
        chk(acc_ready == 1'b0 && rsp_valid == 1'b1, "R9", "read waits, reply held",
            int'({acc_ready, rsp_valid}), 1);
        @(posedge clk); #1 rsp_ready = 1'b1;
      end
    join
    idle(12);

    // R7: nothing lost
    chk(exp_rsp.size() == 0, "R7", "replies outstanding", exp_rsp.size(), 0);
    for (int q = 0; q < 4; q++)
      chk(exp_out[q].size() == 0, "R7", "packets outstanding", exp_out[q].size(), 0);
    finish_run();
  end
endmodule